// File: doc/BRIEF.md
# Multi-Lane Serial Sample Word Serializer

This block turns a set of parallel converter sample words into narrow serial streams. Once per sample period it takes one 12-bit word for each of eight channels. It then sends each word out on a separate single-bit lane, one bit per cycle of a fast clock that runs at twelve times the sample rate. The fast clock stands in for a multiplied clock from a frequency synthesizer.

Two timing outputs travel with the data. The first is a bit clock at half the fast-clock rate, so every bit-clock level, high or low, carries one data bit. The second is a frame clock at the sample rate, which marks where each word starts. A receiver uses these two outputs to recover the bits and the word boundaries. A configuration input picks whether the most significant bit or the least significant bit goes first.

All lanes load on the same cycle and shift together. If no strobe arrives at the end of a word, the block sends the held words again on its own. If a strobe arrives without new words, the block resends the words it last captured.

Top module: `adc_lane_serializer`

## Requirements
- R1: Lane i (0 to 7) carries the word on bits [12*i+11 : 12*i] of `words_in`. Each word takes exactly 12 consecutive fast-clock cycles, called slots 0 to 11.
- R2: Slot 0 is driven in the first cycle after the clock edge that samples `sample_strobe` high. With `msb_first` = 1, slot k carries word bit 11-k. With `msb_first` = 0, slot k carries word bit k.
- R3: While the block is running, `bit_clk` changes level on every fast-clock cycle. It is 1 during the even slots and 0 during the odd slots, so a level lasts one bit.
- R4: `frame_clk` is 1 during slots 0 to 5 and 0 during slots 6 to 11. It rises in the same cycle that slot 0 of a word is driven.
- R5: All eight lanes load on the same edge and shift in lockstep, so slot k of every lane appears in the same cycle.
- R6: `msb_first` is sampled only on the edge that starts a word. A change during slots 0 to 11 leaves the rest of that word unchanged and applies from the next word.
- R7: Synchronous active-low reset drives every lane, `bit_clk` and `frame_clk` to 0. They stay at 0 until the first `sample_strobe`, which starts a word at slot 0.
- R8: A strobe with `words_valid` = 0 resends the last captured words. A strobe with `words_valid` = 1 captures `words_in`. The held words reset to zero.
- R9: When slot 11 ends with no strobe, the block starts a new word from the held words at once. It uses the `msb_first` value present at that boundary.
- R10: A strobe that arrives during slot 11 starts the next word with no gap. The frame clock and bit clock stay continuous across the boundary.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast clock, twelve times the sample rate |
| rst_n | input | 1 | Synchronous reset, active low |
| sample_strobe | input | 1 | One-cycle pulse that starts a word |
| words_valid | input | 1 | `words_in` holds new words with this strobe |
| words_in | input | 96 | Eight 12-bit words, lane 0 in the low bits |
| msb_first | input | 1 | 1 sends the MSB first, 0 sends the LSB first |
| lane_out | output | 8 | Serial data, one bit per lane |
| bit_clk | output | 1 | Bit clock, one level per data bit |
| frame_clk | output | 1 | Word clock, high for the first half of a word |

## Verification
The bit-clock toggle check assumes that strobes arrive only during slot 11, or while the block is idle. A strobe in the middle of a word would restart the slot count and break the alternating level on purpose. The stimulus drives each strobe in the last slot of the previous word, or after reset. The mid-word order change moves only `msb_first`, never the strobe. The reset checks assert `rst_n` on a falling clock edge, so every clocked property starts from a register state that the reset has already set.

// File: rtl/adcser_pkg.sv
// Package adcser_pkg
// Holds the default geometry and the bit-order encoding shared by the
// serializer modules. It assumes nothing about clocks or reset.
package adcser_pkg;

    localparam int DEF_LANES  = 8;
    localparam int DEF_WORD_W = 12;

    // Bit-order selection: 1 sends the MSB first, 0 sends the LSB first.
    typedef enum logic {
        ORDER_LSB_FIRST = 1'b0,
        ORDER_MSB_FIRST = 1'b1
    } bit_order_e;

endpackage

// File: rtl/slot_sequencer.sv
// Module slot_sequencer
// Counts the bit slots of each word and produces the word-load pulse,
// the frame clock and the bit clock.
// Assumptions: WORD_W is even; strobes arrive in the last slot or while idle.
module slot_sequencer #(
    parameter int WORD_W = adcser_pkg::DEF_WORD_W
) (
    input  logic clk,
    input  logic rst_n,
    input  logic strobe_i,
    output logic load_o,
    output logic active_o,
    output logic frame_clk_o,
    output logic bit_clk_o
);
    localparam int SLOT_W = (WORD_W > 2) ? $clog2(WORD_W) : 1;
    localparam int LAST   = WORD_W - 1;
    localparam int HALF   = WORD_W / 2;

    logic [SLOT_W-1:0] slot_q;
    logic [SLOT_W-1:0] slot_nx;
    logic              active_q;
    logic              frame_q;
    logic              bclk_q;

    // Start a word on a strobe, or at the end of a running word.
    assign load_o = strobe_i | (active_q && (slot_q == SLOT_W'(LAST)));

    // Compute the slot that follows the current one.
    always_comb begin
        slot_nx = load_o ? '0 : slot_q + SLOT_W'(1);
    end

    // Update the slot counter and the registered timing outputs.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            slot_q   <= '0;
            active_q <= 1'b0;
            frame_q  <= 1'b0;
            bclk_q   <= 1'b0;
        end else if (load_o) begin
            slot_q   <= '0;
            active_q <= 1'b1;
            frame_q  <= 1'b1;
            bclk_q   <= 1'b1;
        end else if (active_q) begin
            slot_q  <= slot_nx;
            frame_q <= (slot_nx < SLOT_W'(HALF));
            bclk_q  <= ~slot_nx[0];
        end
    end

    assign active_o    = active_q;
    assign frame_clk_o = frame_q;
    assign bit_clk_o   = bclk_q;

    AST_BCLK_TOGGLE: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(active_q) && !$past(strobe_i)) |-> (bclk_q != $past(bclk_q))); // R3
    AST_FRAME_RISE_ON_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(frame_q) |-> bclk_q); // R4
    AST_LOAD_STARTS_WORD: assert property (@(posedge clk) disable iff (!rst_n)
        load_o |=> (frame_q && bclk_q && active_q)); // R10

endmodule

// File: rtl/word_holder.sv
// Module word_holder
// Keeps the last captured set of channel words and supplies the words for
// the next load: the fresh inputs when they are captured, otherwise the
// held copy. Assumes that capture is a single-cycle qualifier.
module word_holder #(
    parameter int N_LANES = adcser_pkg::DEF_LANES,
    parameter int WORD_W  = adcser_pkg::DEF_WORD_W
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      capture_i,
    input  logic [N_LANES*WORD_W-1:0] words_i,
    output logic [N_LANES*WORD_W-1:0] src_o
);
    localparam int BUS_W = N_LANES * WORD_W;

    logic [BUS_W-1:0] held_q;

    // Capture new words only when the strobe brings them.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            held_q <= '0;
        end else if (capture_i) begin
            held_q <= words_i;
        end
    end

    // Pass fresh words straight through in their capture cycle.
    assign src_o = capture_i ? words_i : held_q;

    AST_HOLD_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
        !capture_i |=> $stable(held_q)); // R8

endmodule

// File: rtl/lane_shifter.sv
// Module lane_shifter
// Serializes one channel word onto one lane. At load it fixes the bit order
// and drives the first bit, then sends one bit per clock.
// Assumes the load pulse comes from the shared sequencer.
module lane_shifter #(
    parameter int WORD_W = adcser_pkg::DEF_WORD_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load_i,
    input  logic              msb_first_i,
    input  logic [WORD_W-1:0] word_i,
    output logic              lane_o
);
    import adcser_pkg::*;

    logic [WORD_W-1:0] reversed;
    logic [WORD_W-1:0] ordered;
    logic [WORD_W-1:0] sh_q;
    logic              q_q;
    bit_order_e        order;

    // Mirror the word so that LSB-first reuses the MSB-side shift path.
    for (genvar b = 0; b < WORD_W; b++) begin : g_rev
        assign reversed[b] = word_i[WORD_W-1-b];
    end

    assign order   = bit_order_e'(msb_first_i);
    assign ordered = (order == ORDER_MSB_FIRST) ? word_i : reversed;

    // Load a word and drive its first bit, or send the next bit.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sh_q <= '0;
            q_q  <= 1'b0;
        end else if (load_i) begin
            q_q  <= ordered[WORD_W-1];
            sh_q <= {ordered[WORD_W-2:0], 1'b0};
        end else begin
            q_q  <= sh_q[WORD_W-1];
            sh_q <= {sh_q[WORD_W-2:0], 1'b0};
        end
    end

    assign lane_o = q_q;

endmodule

// File: rtl/adc_lane_serializer.sv
// Module adc_lane_serializer
// Top level. Sends N_LANES parallel sample words out as serial lanes, with
// a bit clock and a frame clock. All logic runs on the fast clock
// (WORD_W times the sample rate), with a synchronous active-low reset.
module adc_lane_serializer #(
    parameter int N_LANES = adcser_pkg::DEF_LANES,
    parameter int WORD_W  = adcser_pkg::DEF_WORD_W
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      sample_strobe,
    input  logic                      words_valid,
    input  logic [N_LANES*WORD_W-1:0] words_in,
    input  logic                      msb_first,
    output logic [N_LANES-1:0]        lane_out,
    output logic                      bit_clk,
    output logic                      frame_clk
);
    localparam int BUS_W = N_LANES * WORD_W;

    logic             load;
    logic             active;
    logic [BUS_W-1:0] src_words;

    slot_sequencer #(.WORD_W(WORD_W)) i_seq (
        .clk         (clk),
        .rst_n       (rst_n),
        .strobe_i    (sample_strobe),
        .load_o      (load),
        .active_o    (active),
        .frame_clk_o (frame_clk),
        .bit_clk_o   (bit_clk)
    );

    word_holder #(.N_LANES(N_LANES), .WORD_W(WORD_W)) i_hold (
        .clk       (clk),
        .rst_n     (rst_n),
        .capture_i (sample_strobe & words_valid),
        .words_i   (words_in),
        .src_o     (src_words)
    );

    // One shifter per lane, all driven by the same load pulse.
    for (genvar l = 0; l < N_LANES; l++) begin : g_lane
        lane_shifter #(.WORD_W(WORD_W)) i_shift (
            .clk         (clk),
            .rst_n       (rst_n),
            .load_i      (load),
            .msb_first_i (msb_first),
            .word_i      (src_words[l*WORD_W +: WORD_W]),
            .lane_o      (lane_out[l])
        );
    end

    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !active |-> (lane_out == '0 && !frame_clk && !bit_clk)); // R7

endmodule

// File: tb/test_adc_lane_serializer.sv
module test_adc_lane_serializer;
    localparam int NL = 8;
    localparam int WW = 12;

    // Vector fields: [13] words_valid, [12] msb_first, [11:0] seed.
    localparam logic [13:0] VEC [0:5] = '{
        {1'b1, 1'b1, 12'hA5C},
        {1'b1, 1'b0, 12'h3C7},
        {1'b0, 1'b1, 12'h000},
        {1'b1, 1'b1, 12'hFFF},
        {1'b0, 1'b0, 12'h123},
        {1'b1, 1'b0, 12'h801}
    };

    logic             clk = 1'b0;
    logic             rst_n;
    logic             strobe;
    logic             valid;
    logic             msb;
    logic [NL*WW-1:0] words;
    logic [NL-1:0]    lane_out;
    logic             bit_clk;
    logic             frame_clk;

    int               n_vec = 0;
    int               n_bad = 0;
    logic [WW-1:0]    exp_w [NL];
    logic             exp_order;

    always #10 clk = ~clk;

    adc_lane_serializer i_adc_lane_serializer (
        .clk           (clk),
        .rst_n         (rst_n),
        .sample_strobe (strobe),
        .words_valid   (valid),
        .words_in      (words),
        .msb_first     (msb),
        .lane_out      (lane_out),
        .bit_clk       (bit_clk),
        .frame_clk     (frame_clk)
    );

    function automatic logic [WW-1:0] wcalc(logic [WW-1:0] seed, int lane);
        return (seed ^ WW'(lane * 12'h2C5)) + WW'(lane);
    endfunction

    task automatic report();
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    endtask

    // Compare one slot of all lanes plus both timing outputs (R1 R2 R3 R4 R5).
    task automatic check_slot(int k, string tag);
        logic [NL-1:0] el;
        logic ef, eb;
        for (int i = 0; i < NL; i++)
            el[i] = exp_order ? exp_w[i][WW-1-k] : exp_w[i][k];
        ef = (k < WW/2);
        eb = (k % 2 == 0);
        n_vec++;
        if (lane_out !== el || frame_clk !== ef || bit_clk !== eb) begin
            n_bad++;
            $display("FAIL %s slot %0d: lanes=%b frame=%b bclk=%b expected lanes=%b frame=%b bclk=%b",
                     tag, k, lane_out, frame_clk, bit_clk, el, ef, eb);
        end
    endtask

    task automatic check_idle(string tag);
        n_vec++;
        if (lane_out !== '0 || frame_clk !== 1'b0 || bit_clk !== 1'b0) begin
            n_bad++;
            $display("FAIL %s: lanes=%b frame=%b bclk=%b expected lanes=0 frame=0 bclk=0",
                     tag, lane_out, frame_clk, bit_clk);
        end
    endtask

    // Called at a falling edge; strobes once and checks all 12 slots.
    task automatic run_word(logic v, logic m, logic [WW-1:0] seed, int flip_at, string tag);
        strobe = 1'b1;
        valid  = v;
        msb    = m;
        for (int i = 0; i < NL; i++) words[i*WW +: WW] = wcalc(seed, i);
        if (v) for (int i = 0; i < NL; i++) exp_w[i] = wcalc(seed, i);
        exp_order = m;
        @(negedge clk);
        strobe = 1'b0;
        valid  = 1'b0;
        words  = '1;
        for (int k = 0; k < WW; k++) begin
            if (k > 0) @(negedge clk);
            check_slot(k, tag);
            if (k == flip_at) msb = ~msb;
        end
    endtask

    // No strobe: the block must restart from the held words by itself (R9).
    task automatic run_wrap(string tag);
        exp_order = msb;
        for (int k = 0; k < WW; k++) begin
            @(negedge clk);
            check_slot(k, tag);
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog: run did not finish, actual timeout expected completion");
        report();
        $finish;
    end

    initial begin
        rst_n  = 1'b0;
        strobe = 1'b0;
        valid  = 1'b0;
        msb    = 1'b1;
        words  = '0;
        for (int i = 0; i < NL; i++) exp_w[i] = '0;
        exp_order = 1'b1;
        repeat (3) @(negedge clk);
        check_idle("R7 during reset");
        rst_n = 1'b1;
        for (int c = 0; c < 4; c++) begin
            @(negedge clk);
            check_idle("R7 idle before first strobe");
        end

        // Table walk: strobes in slot 11 of each previous word (R1 R2 R5 R8 R10).
        for (int v = 0; v < 6; v++)
            run_word(VEC[v][13], VEC[v][12], VEC[v][11:0], -1, "R10 table vector");

        // Order flip in mid-word has no effect until the boundary (R6).
        run_word(1'b1, 1'b1, 12'h5A3, 5, "R6 order held mid-word");
        // The next word restarts on its own with the new order (R9).
        run_wrap("R9 self restart LSB-first");
        msb = 1'b1;
        run_wrap("R9 self restart MSB-first");

        // Strobe without new words resends the held set (R8).
        run_word(1'b0, 1'b0, 12'hBEE, -1, "R8 resend held words");

        // Reset in mid-stream returns to the quiet state (R7).
        @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        check_idle("R7 reset mid-word");
        rst_n = 1'b1;
        for (int i = 0; i < NL; i++) exp_w[i] = '0;
        for (int c = 0; c < 3; c++) begin
            @(negedge clk);
            check_idle("R7 idle after second reset");
        end
        // Held words were cleared: a strobe without new words sends zeros (R8).
        run_word(1'b0, 1'b1, 12'hABC, -1, "R8 held words cleared by reset");
        run_word(1'b1, 1'b0, 12'h6D9, -1, "R2 fresh word after reset LSB-first");

        report();
        $finish;
    end
endmodule